// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words and returns one rounded result per clock. Operands enter with `in_valid`. Exactly five cycles later the sum leaves with `out_valid`. A new operand pair can be accepted on every cycle, so a stream of back-to-back operations comes out at the same rate and in the same order.

Inside, the work is split into fixed phases. Stage one unpacks both words, classifies special values and orders the operands by magnitude. Stage two aligns the smaller significand to the larger exponent. Stage three adds or subtracts the significands. Stage four renormalizes the sum, either by a one-place right shift on a carry or by a priority-encoded left shift that lowers the exponent. Stage five rounds to nearest, ties to even, then packs the word or substitutes a special value.

Subtraction reuses the adder: asserting `op_sub` inverts the sign of the second operand before anything else happens. Inputs whose exponent field is zero are treated as zero, and results too small for a normal exponent are returned as zero.

Top module: `fpadd_pipe`

## Requirements
- R1: A word holds its sign in bit 31, an exponent field biased by 127 in bits 30:23, and the fraction in bits 22:0. A normal input has a hidden leading 1. Any input whose exponent field is 0 acts as a zero carrying that word's sign, so 0x00000001 + 0x3F800000 gives 0x3F800000.
- R2: `out_valid` rises exactly 5 cycles after each accepted `in_valid`. Consecutive inputs give consecutive outputs in issue order, one per cycle. No output appears without a matching input.
- R3: With `op_sub` = 1 the result is a − b, formed by inverting b's sign bit, so 0x40000000 − 0x3F800000 = 0x3F800000.
- R4: The smaller-magnitude significand is shifted right by the exponent difference. Bits beyond the guard and round positions collapse into a sticky bit, so 0x4CBEBC20 + 0x3F800000 (1e8 + 1) returns 0x4CBEBC20.
- R5: When the significand sum carries out, it shifts right one place and the exponent rises by one, so 0x3FC00000 + 0x3FC00000 = 0x40400000.
- R6: When the difference has leading zeros, it shifts left by the leading-zero count and the exponent drops by the same count. Every nonzero normalized significand has its top bit set. 0x3F800000 − 0x3F800001 = 0xB4000000.
- R7: Rounding is to nearest with ties to even, using guard, round and sticky. A rounding carry bumps the exponent. 0x3F800000 + 0x33800000 = 0x3F800000, and 0x3F800001 + 0x33800000 = 0x3F800002.
- R8: A result exponent that reaches 255 yields infinity with the result's sign (0x7F800000 or 0xFF800000).
- R9: Infinity plus a finite value returns that infinity. Infinities of opposite effective sign give 0x7FC00000.
- R10: A NaN on either input gives exactly 0x7FC00000. No other NaN encoding is ever produced.
- R11: An exact cancellation gives +0. The sum of two zeros is −0 only when both effective signs are negative. A result whose normalized exponent is below 1 becomes a zero with the result's sign.
- R12: While reset is asserted and right after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | Rounded sum or difference |

## Verification
The bench builds the block with the package defaults: an 8-bit exponent and a 23-bit fraction. At these widths the hand-derived single-precision encodings used by the directed cases are exact. These cover absorption of 1 into 1e8, the half-ulp tie at 2^-24 with both parities of the last bit, the largest finite value doubling into infinity, and the one-ulp difference between the two smallest normals that underflows to a signed zero. A randomized stream drives exponent differences that straddle the 27-bit alignment window, and also near-equal pairs whose cancellation exercises long left shifts. Each of these outputs is compared against an exact wide-integer model.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;
  // pipeline depth is structural: unpack, align, add, normalize, round
  localparam int LATENCY = 5;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EXT_W   = SIG_W + 3;   // significand plus guard, round, sticky
  localparam int WEXP_W  = EXP_W + 2;   // signed working exponent
  localparam int LZ_W    = $clog2(EXT_W + 1);
  localparam logic [EXP_W-1:0]  EXP_ALL1 = '1;
  localparam logic [WORD_W-1:0] QNAN_W   = {1'b0, EXP_ALL1, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              sign;
    logic              eff_sub;
    logic              zsign;
    logic              special;
    logic [WORD_W-1:0] spec_val;
    logic [EXP_W-1:0]  exp;
    logic [SIG_W-1:0]  big_sig;
    logic [SIG_W-1:0]  small_sig;
    logic [EXP_W-1:0]  shamt;
  } unpk_t;

  typedef struct packed {
    logic              sign;
    logic              eff_sub;
    logic              zsign;
    logic              special;
    logic [WORD_W-1:0] spec_val;
    logic [EXP_W-1:0]  exp;
    logic [EXT_W-1:0]  big_x;
    logic [EXT_W-1:0]  small_x;
  } algn_t;

  typedef struct packed {
    logic              sign;
    logic              zsign;
    logic              special;
    logic [WORD_W-1:0] spec_val;
    logic [EXP_W-1:0]  exp;
    logic [EXT_W:0]    sum;
  } sum_t;

  typedef struct packed {
    logic              sign;
    logic              zsign;
    logic              special;
    logic              zero;
    logic              uflow;
    logic [WORD_W-1:0] spec_val;
    logic [WEXP_W-1:0] exp;
    logic [EXT_W-1:0]  sig;
  } norm_t;

  function automatic logic is_nan(input logic [WORD_W-1:0] w);
    return (w[WORD_W-2:FRAC_W] == EXP_ALL1) && (w[FRAC_W-1:0] != '0);
  endfunction

  function automatic logic is_inf(input logic [WORD_W-1:0] w);
    return (w[WORD_W-2:FRAC_W] == EXP_ALL1) && (w[FRAC_W-1:0] == '0);
  endfunction

  // priority encoder: count of zeros above the highest set bit
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (v[i]) n = LZ_W'(EXT_W - 1 - i);
    return n;
  endfunction

  // right shift that ORs every discarded bit into bit 0
  function automatic logic [EXT_W-1:0] shr_sticky(input logic [EXT_W-1:0] v,
                                                  input logic [EXP_W-1:0] sh);
    logic [EXT_W-1:0] kept;
    logic [EXT_W-1:0] lost;
    if (int'(sh) >= EXT_W) return {{(EXT_W-1){1'b0}}, |v};
    kept = v >> sh;
    lost = v & ~({EXT_W{1'b1}} << sh);
    return {kept[EXT_W-1:1], kept[0] | (|lost)};
  endfunction

  // nearest-even increment; top bit of the return is the carry out
  function automatic logic [SIG_W:0] round_rne(input logic [EXT_W-1:0] s);
    logic [SIG_W-1:0] keep;
    logic             up;
    keep = s[EXT_W-1:3];
    up   = s[2] & (s[1] | s[0] | keep[0]);
    return {1'b0, keep} + {{SIG_W{1'b0}}, up};
  endfunction
endpackage

// File: rtl/fpadd_unpack.sv
`timescale 1ns/1ps
module fpadd_unpack
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic              u_valid,
  output unpk_t             u_q
);
  logic             sa, sb, a_big;
  logic [EXP_W-1:0] ea, eb;
  logic [SIG_W-1:0] ma, mb;
  unpk_t            d;

  always_comb begin
    sa = a[WORD_W-1];
    sb = b[WORD_W-1] ^ op_sub;
    ea = a[WORD_W-2:FRAC_W];
    eb = b[WORD_W-2:FRAC_W];
    ma = (ea == '0) ? '0 : {1'b1, a[FRAC_W-1:0]};
    mb = (eb == '0) ? '0 : {1'b1, b[FRAC_W-1:0]};
    a_big = {ea, ma} >= {eb, mb};
    d = '0;
    d.eff_sub   = sa ^ sb;
    d.zsign     = sa & sb;
    d.sign      = a_big ? sa : sb;
    d.exp       = a_big ? ea : eb;
    d.big_sig   = a_big ? ma : mb;
    d.small_sig = a_big ? mb : ma;
    d.shamt     = a_big ? (ea - eb) : (eb - ea);
    if (is_nan(a) || is_nan(b)) begin
      d.special  = 1'b1;
      d.spec_val = QNAN_W;
    end else if (is_inf(a) && is_inf(b)) begin
      d.special  = 1'b1;
      d.spec_val = (sa != sb) ? QNAN_W : {sa, EXP_ALL1, {FRAC_W{1'b0}}};
    end else if (is_inf(a)) begin
      d.special  = 1'b1;
      d.spec_val = {sa, EXP_ALL1, {FRAC_W{1'b0}}};
    end else if (is_inf(b)) begin
      d.special  = 1'b1;
      d.spec_val = {sb, EXP_ALL1, {FRAC_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_valid <= 1'b0;
      u_q     <= '0;
    end else begin
      u_valid <= in_valid;
      u_q     <= d;
    end
  end
endmodule

// File: rtl/fpadd_align.sv
`timescale 1ns/1ps
module fpadd_align
  import fpadd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  u_valid,
  input  unpk_t u_q,
  output logic  al_valid,
  output algn_t al_q
);
  algn_t d;

  always_comb begin
    d.sign     = u_q.sign;
    d.eff_sub  = u_q.eff_sub;
    d.zsign    = u_q.zsign;
    d.special  = u_q.special;
    d.spec_val = u_q.spec_val;
    d.exp      = u_q.exp;
    d.big_x    = {u_q.big_sig, 3'b000};
    d.small_x  = shr_sticky({u_q.small_sig, 3'b000}, u_q.shamt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_valid <= 1'b0;
      al_q     <= '0;
    end else begin
      al_valid <= u_valid;
      al_q     <= d;
    end
  end
endmodule

// File: rtl/fpadd_norm.sv
`timescale 1ns/1ps
module fpadd_norm
  import fpadd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_valid,
  input  sum_t  s_q,
  output logic  n_valid,
  output norm_t n_q
);
  logic                     carry;
  logic [EXT_W-1:0]         body;
  logic [LZ_W-1:0]          lz;
  logic signed [WEXP_W-1:0] e_in, e_out;
  norm_t                    d;

  always_comb begin
    carry = s_q.sum[EXT_W];
    body  = s_q.sum[EXT_W-1:0];
    lz    = lead_zeros(body);
    e_in  = $signed({2'b00, s_q.exp});
    d     = '0;
    if (carry) begin
      // one-place right shift keeps the dropped bit in sticky
      d.sig = {s_q.sum[EXT_W:2], s_q.sum[1] | s_q.sum[0]};
      e_out = e_in + $signed(WEXP_W'(1));
    end else begin
      d.sig = body << lz;
      e_out = e_in - $signed({{(WEXP_W-LZ_W){1'b0}}, lz});
    end
    d.zero     = !carry && (body == '0);
    d.uflow    = !d.zero && (e_out < $signed(WEXP_W'(1)));
    d.exp      = e_out;
    d.sign     = s_q.sign;
    d.zsign    = s_q.zsign;
    d.special  = s_q.special;
    d.spec_val = s_q.spec_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_valid <= 1'b0;
      n_q     <= '0;
    end else begin
      n_valid <= s_valid;
      n_q     <= d;
    end
  end
endmodule

// File: rtl/fpadd_round.sv
`timescale 1ns/1ps
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              n_valid,
  input  norm_t             n_q,
  output logic              r_valid,
  output logic [WORD_W-1:0] r_word
);
  logic [SIG_W:0]           r;
  logic signed [WEXP_W-1:0] e;
  logic [FRAC_W-1:0]        mant;
  logic [WORD_W-1:0]        d;

  always_comb begin
    r    = round_rne(n_q.sig);
    e    = $signed(n_q.exp) + $signed({{(WEXP_W-1){1'b0}}, r[SIG_W]});
    mant = r[SIG_W] ? r[FRAC_W:1] : r[FRAC_W-1:0];
    if (n_q.special)
      d = n_q.spec_val;
    else if (n_q.zero)
      d = {n_q.zsign, {(WORD_W-1){1'b0}}};
    else if (n_q.uflow)
      d = {n_q.sign, {(WORD_W-1){1'b0}}};
    else if (e >= $signed({2'b00, EXP_ALL1}))
      d = {n_q.sign, EXP_ALL1, {FRAC_W{1'b0}}};
    else
      d = {n_q.sign, e[EXP_W-1:0], mant};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_word  <= '0;
    end else begin
      r_valid <= n_valid;
      r_word  <= d;
    end
  end
endmodule

// File: rtl/fpadd_pipe.sv
`timescale 1ns/1ps
module fpadd_pipe
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  logic  u_valid;
  unpk_t u_q;
  logic  al_valid;
  algn_t al_q;
  logic  s_valid;
  sum_t  s_d, s_q;
  logic  norm_valid;
  norm_t n_q;
  // observation points for the checker
  logic  norm_lead;
  logic  norm_zero;

  fpadd_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .a(a), .b(b), .u_valid(u_valid), .u_q(u_q)
  );

  fpadd_align u_align (
    .clk(clk), .rst_n(rst_n), .u_valid(u_valid), .u_q(u_q),
    .al_valid(al_valid), .al_q(al_q)
  );

  // stage three: significand add or subtract, larger magnitude first
  always_comb begin
    s_d.sign     = al_q.sign;
    s_d.zsign    = al_q.zsign;
    s_d.special  = al_q.special;
    s_d.spec_val = al_q.spec_val;
    s_d.exp      = al_q.exp;
    if (al_q.eff_sub) s_d.sum = {1'b0, al_q.big_x} - {1'b0, al_q.small_x};
    else              s_d.sum = {1'b0, al_q.big_x} + {1'b0, al_q.small_x};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_q     <= '0;
    end else begin
      s_valid <= al_valid;
      s_q     <= s_d;
    end
  end

  fpadd_norm u_norm (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_q(s_q),
    .n_valid(norm_valid), .n_q(n_q)
  );

  assign norm_lead = n_q.sig[EXT_W-1];
  assign norm_zero = n_q.zero;

  fpadd_round u_round (
    .clk(clk), .rst_n(rst_n), .n_valid(norm_valid), .n_q(n_q),
    .r_valid(out_valid), .r_word(result)
  );
endmodule

// File: rtl/fpadd_pipe_chk.sv
`timescale 1ns/1ps
module fpadd_pipe_chk
  import fpadd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] a,
  input logic [WORD_W-1:0] b,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic              norm_valid,
  input logic              norm_lead,
  input logic              norm_zero
);
  logic [3:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age < 4'(LATENCY)) age <= age + 4'd1;
  end
  wire warm       = (age >= 4'(LATENCY));
  wire a_nan_in   = in_valid && is_nan(a);
  wire a_inf_fin  = in_valid && is_inf(a) && !is_nan(b) && !is_inf(b);
  wire out_is_nan = out_valid && is_nan(result);

  // R2
  latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, LATENCY)));

  // R6
  norm_lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_valid && !norm_zero) |-> norm_lead);

  // R10
  nan_in_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(a_nan_in, LATENCY)) |-> (result == QNAN_W));

  // R10
  canon_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_nan |-> (result == QNAN_W));

  // R9
  inf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(a_inf_fin, LATENCY)) |-> (result == $past(a, LATENCY)));
endmodule

bind fpadd_pipe fpadd_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .result(result), .norm_valid(norm_valid),
  .norm_lead(norm_lead), .norm_zero(norm_zero)
);

// File: tb/fpadd_pipe_tb.sv
`timescale 1ns/1ps
module fpadd_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        out_valid;
  logic [31:0] result;

  fpadd_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .a(a), .b(b), .out_valid(out_valid), .result(result)
  );

  always #2 clk = ~clk;   // 250 MHz

  int unsigned cyc = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    logic [31:0] expv;
    int unsigned issued;
    string       tag;
  } item_t;
  item_t sbq[$];

  int checks = 0;
  int fails  = 0;

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  // exact wide-integer model of the requirements
  function automatic logic [31:0] ref_add(input logic [31:0] x, input logic [31:0] y, input bit sub);
    bit sx, sy, neg;
    int ex, ey, emin, p, e, sh;
    longint vx, vy, tot, mag, keep, rem, half;
    sx = x[31]; sy = y[31] ^ sub;
    ex = int'(x[30:23]); ey = int'(y[30:23]);
    if ((ex == 255 && x[22:0] != 0) || (ey == 255 && y[22:0] != 0)) return 32'h7FC00000;
    if (ex == 255 && ey == 255) return (sx != sy) ? 32'h7FC00000 : {sx, 8'hFF, 23'h0};
    if (ex == 255) return {sx, 8'hFF, 23'h0};
    if (ey == 255) return {sy, 8'hFF, 23'h0};
    if (ex == 0 && ey == 0) return {sx & sy, 31'h0};
    if (ex == 0) return {sy, y[30:0]};
    if (ey == 0) return x;
    if (ex - ey > 32) return x;
    if (ey - ex > 32) return {sy, y[30:0]};
    emin = (ex < ey) ? ex : ey;
    vx = longint'({1'b1, x[22:0]}) << (ex - emin);
    vy = longint'({1'b1, y[22:0]}) << (ey - emin);
    tot = (sx ? -vx : vx) + (sy ? -vy : vy);
    if (tot == 0) return 32'h0;
    neg = (tot < 0);
    mag = neg ? -tot : tot;
    p = 0;
    for (int i = 0; i < 63; i++) if (mag[i]) p = i;
    e = emin + p - 23;
    if (p > 23) begin
      sh   = p - 23;
      keep = mag >> sh;
      rem  = mag & ((64'sd1 << sh) - 1);
      half = 64'sd1 << (sh - 1);
      if (rem > half || (rem == half && keep[0])) keep = keep + 1;
      if (keep == (64'sd1 << 24)) begin
        keep = keep >> 1;
        e = e + 1;
      end
    end else begin
      keep = mag << (23 - p);
    end
    if (e >= 255) return {neg, 8'hFF, 23'h0};
    if (e <= 0) return {neg, 31'h0};
    return {neg, e[7:0], keep[22:0]};
  endfunction

  task automatic send(input logic [31:0] x, input logic [31:0] y, input bit s,
                      input logic [31:0] expv, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; a = x; b = y; op_sub = s;
    it.expv = expv; it.issued = cyc; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops in order, checks value and exact latency
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sbq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: got unexpected out_valid expected none");
      end else begin
        item_t it;
        it = sbq.pop_front();
        check_val(it.tag, result, it.expv);
        check_val("R2 latency", 32'(cyc - it.issued), 32'd5);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_val("R12 in reset", {31'h0, out_valid}, 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R12 after reset", {31'h0, out_valid}, 32'h0);

    send(32'h00000001, 32'h3F800000, 0, 32'h3F800000, "R1 subnormal flush");
    send(32'h00400000, 32'h80400000, 0, 32'h00000000, "R1 two subnormals");
    send(32'h40000000, 32'h3F800000, 1, 32'h3F800000, "R3 2-1");
    send(32'h3F800000, 32'hBF800000, 1, 32'h40000000, "R3 1-(-1)");
    send(32'h4CBEBC20, 32'h3F800000, 0, 32'h4CBEBC20, "R4 absorption");
    send(32'h3FC00000, 32'h3FC00000, 0, 32'h40400000, "R5 carry renorm");
    send(32'h3F800000, 32'h3F800001, 1, 32'hB4000000, "R6 leading zeros");
    send(32'h3F800000, 32'h33800000, 0, 32'h3F800000, "R7 tie even down");
    send(32'h3F800001, 32'h33800000, 0, 32'h3F800002, "R7 tie even up");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 32'h7F800000, "R8 overflow pos");
    send(32'hFF7FFFFF, 32'hFF7FFFFF, 0, 32'hFF800000, "R8 overflow neg");
    send(32'h7F800000, 32'h3F800000, 0, 32'h7F800000, "R9 inf+finite");
    send(32'hFF800000, 32'h7F800000, 0, 32'h7FC00000, "R9 inf-inf");
    send(32'h3F800000, 32'h7F800000, 1, 32'hFF800000, "R9 finite-inf");
    send(32'h7FC00001, 32'h3F800000, 0, 32'h7FC00000, "R10 nan a");
    send(32'h3F800000, 32'hFF812345, 0, 32'h7FC00000, "R10 nan b");
    send(32'h3F800000, 32'h3F800000, 1, 32'h00000000, "R11 exact cancel");
    send(32'h80000000, 32'h80000000, 0, 32'h80000000, "R11 neg zeros");
    send(32'h00800000, 32'h00800001, 1, 32'h80000000, "R11 underflow");
    idle(3);

    for (int k = 0; k < 600; k++) begin
      logic [31:0] x, y;
      int ea, eb, mode;
      bit s;
      ea   = 30 + int'($urandom % 190);
      mode = int'($urandom % 4);
      case (mode)
        0: eb = ea + int'($urandom % 7) - 3;
        1: eb = 30 + int'($urandom % 190);
        2: eb = ea;
        default: eb = ea - 23 - int'($urandom % 8);
      endcase
      s = bit'($urandom % 2);
      x = {1'($urandom), 8'(ea), 23'($urandom)};
      if (mode == 2) y = {1'($urandom), x[30:0] ^ {23'h0, 8'($urandom)}};
      else           y = {1'($urandom), 8'(eb), 23'($urandom)};
      send(x, y, s, ref_add(x, y, s), "R4/R6/R7 random");
      if ($urandom % 6 == 0) idle(int'($urandom % 3) + 1);
    end
    idle(1);
    while (sbq.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule